// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller that groups its pins into banks of up to 32. Software reaches it through a plain register port (address, write data, write enable, read enable, read data). For every bank it offers a synchronised pin-level view, a direction register, separate set and clear strobe registers that move the output latch, rising- and falling-edge enables, a sticky edge status register cleared by writing ones, and an edge mask that decides which status bits may raise the single interrupt line.

The registers of neighbouring banks sit four bytes apart within each register type. The first three banks live in a low window starting at 0x000, and banks 3 and above live in a second window starting at 0x100. The number of banks, the pin count of the last bank, and a global range of pins whose direction bit has inverted polarity are all parameters.

Pin inputs are brought into the clock domain by two flops. An edge is a difference between the synchronised level and its value one cycle earlier.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: A read is requested by holding `rd_en` high for one cycle, and `rd_data` shows the selected register after the next rising clock edge. `rd_data` keeps its value while `rd_en` is low. Reading an address that decodes to no register returns 0.
- R2: Within a bank the register offsets are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, status 0x48, mask 0x9C. These are added to the bank base. The base is 4*n for banks 0 to 2 and 0x100 + 4*(n-3) for banks 3 to 5. A write to one bank leaves every other bank unchanged.
- R3: Writing a 1 to a bit of the set register drives that pin's output latch high. Writing a 1 to a bit of the clear register drives it low. Zero bits leave their outputs as they were. Both strobe registers read as 0, and `pin_out` changes only in the cycle after a write.
- R4: The level register returns each pin's input two clock edges after it changes at `pin_in`, whatever that pin's direction.
- R5: A direction bit of 1 enables the output driver (`pin_oe` high), except for global pins in the range INV_LO to INV_HI, where 0 enables it. The direction register reads back the raw stored bits, and `pin_oe` changes only after a write.
- R6: A status bit is set on a rising transition of its synchronised pin when its rising enable is 1, and on a falling transition when its falling enable is 1. A transition whose enable is 0 leaves the status bit unchanged. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: `irq` is high exactly when some bank has a status bit set whose mask bit is also 1. Status bits stay readable while they are masked. `irq` falls only after a write.
- R8: The last bank implements LAST_BANK_PINS pins. Its bits above that count read as 0 in every register and ignore writes.
- R9: When a new enabled edge and a write-1-to-clear of the same status bit land in the same cycle, the bit stays set.
- R10: After reset, every pin is an input (`pin_oe` all 0), which means the direction bits of inverted pins read back as 1. The output latches, edge enables, status and masks are all 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 9 | Byte address of the register |
| wr_data | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read request, one cycle per read |
| rd_data | output | 32 | Registered read data |
| pin_in | input | NPINS | Pin input levels (asynchronous) |
| pin_out | output | NPINS | Output latch values |
| pin_oe | output | NPINS | Output driver enables |
| irq | output | 1 | OR of unmasked status bits over all banks |

## Verification
The bench times a status-clear write to land on the same edge that a fresh rising edge is recorded. A design that let the clear win would drop that event and read back 0. It reads the level register one cycle too early and then again, which catches a synchroniser that is one flop short or one flop too long. It also drives the inverted-polarity pins and the unimplemented top bits of the last bank, where a wrong mask would enable the wrong drivers or let phantom bits read back. Accesses to the high window for bank 3, and to decode holes, catch a wrong base formula that would alias banks or return stale data.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W   = 9;
    localparam int BANK_W   = 32;
    localparam int BIDX_W   = 3;
    localparam int MAX_BANK = 6;

    typedef enum logic [2:0] {
        REG_LVL, REG_DIR, REG_SET, REG_CLR,
        REG_RISE, REG_FALL, REG_STS, REG_MSK
    } reg_e;

    typedef struct packed {
        logic              hit;
        logic [BIDX_W-1:0] bank;
        reg_e              sel;
    } dec_t;

    function automatic logic [ADDR_W-1:0] reg_offset(reg_e r);
        case (r)
            REG_LVL:  return 9'h000;
            REG_DIR:  return 9'h00C;
            REG_SET:  return 9'h018;
            REG_CLR:  return 9'h024;
            REG_RISE: return 9'h030;
            REG_FALL: return 9'h03C;
            REG_STS:  return 9'h048;
            default:  return 9'h09C;
        endcase
    endfunction

    // Two windows: banks 0..2 low, banks 3.. from 0x100, 4-byte stride.
    function automatic logic [ADDR_W-1:0] bank_base(int b);
        if (b < 3) return ADDR_W'(b * 4);
        return ADDR_W'(256 + (b - 3) * 4);
    endfunction

    function automatic dec_t decode(logic [ADDR_W-1:0] a, int nbanks);
        dec_t d;
        d = '0;
        for (int b = 0; b < MAX_BANK; b++) begin
            for (int r = 0; r < 8; r++) begin
                if (b < nbanks && a == bank_base(b) + reg_offset(reg_e'(3'(r)))) begin
                    d.hit  = 1'b1;
                    d.bank = BIDX_W'(b);
                    d.sel  = reg_e'(3'(r));
                end
            end
        end
        return d;
    endfunction

    function automatic logic [BANK_W-1:0] inv_mask(int b, int lo, int hi);
        logic [BANK_W-1:0] m;
        for (int i = 0; i < BANK_W; i++) begin
            m[i] = (b * BANK_W + i >= lo) && (b * BANK_W + i <= hi);
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            lvl      <= '0;
            lvl_prev <= '0;
        end else begin
            meta_q   <= din;
            lvl      <= meta_q;
            lvl_prev <= lvl;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int                W        = 32,
    parameter logic [BANK_W-1:0] INV_MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  reg_e              sel,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      lvl,
    input  logic [W-1:0]      lvl_prev,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [BANK_W-1:0] rd_val,
    output logic              irq
);
    localparam logic [W-1:0] INV_W = INV_MASK[W-1:0];

    logic [W-1:0] out_q, dir_q, rise_q, fall_q, sts_q, msk_q;
    logic [W-1:0] evt, sts_clr;

    assign evt     = (lvl & ~lvl_prev & rise_q) | (~lvl & lvl_prev & fall_q);
    assign sts_clr = (we && sel == REG_STS) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= INV_W;
            rise_q <= '0;
            fall_q <= '0;
            sts_q  <= '0;
            msk_q  <= '0;
        end else begin
            // new edge wins over a same-cycle clear
            sts_q <= (sts_q & ~sts_clr) | evt;
            if (we) begin
                case (sel)
                    REG_DIR:  dir_q  <= wdata;
                    REG_SET:  out_q  <= out_q | wdata;
                    REG_CLR:  out_q  <= out_q & ~wdata;
                    REG_RISE: rise_q <= wdata;
                    REG_FALL: fall_q <= wdata;
                    REG_MSK:  msk_q  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (sel)
            REG_LVL:  rd_val = BANK_W'(lvl);
            REG_DIR:  rd_val = BANK_W'(dir_q);
            REG_RISE: rd_val = BANK_W'(rise_q);
            REG_FALL: rd_val = BANK_W'(fall_q);
            REG_STS:  rd_val = BANK_W'(sts_q);
            REG_MSK:  rd_val = BANK_W'(msk_q);
            default:  rd_val = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q ^ INV_W;
    assign irq     = |(sts_q & msk_q);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS      = 4,
    parameter int LAST_BANK_PINS = 20,
    parameter int INV_LO         = 86,
    parameter int INV_HI         = 89,
    localparam int NPINS         = (NUM_BANKS - 1) * BANK_W + LAST_BANK_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    dec_t                  dec;
    logic [NPINS-1:0]      lvl, lvl_prev;
    logic [BANK_W-1:0]     rd_b [NUM_BANKS];
    logic [NUM_BANKS-1:0]  irq_b;
    logic [BANK_W-1:0]     rd_mux;

    assign dec = decode(addr, NUM_BANKS);

    gpio_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .din      (pin_in),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam int W  = (g == NUM_BANKS - 1) ? LAST_BANK_PINS : BANK_W;
        localparam int LO = g * BANK_W;
        logic bank_we;
        assign bank_we = wr_en && dec.hit && dec.bank == BIDX_W'(g);

        gpio_bank #(
            .W        (W),
            .INV_MASK (inv_mask(g, INV_LO, INV_HI))
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .we       (bank_we),
            .sel      (dec.sel),
            .wdata    (wr_data[W-1:0]),
            .lvl      (lvl[LO +: W]),
            .lvl_prev (lvl_prev[LO +: W]),
            .pin_out  (pin_out[LO +: W]),
            .pin_oe   (pin_oe[LO +: W]),
            .rd_val   (rd_b[g]),
            .irq      (irq_b[g])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int g = 0; g < NUM_BANKS; g++) begin
            if (dec.hit && dec.bank == BIDX_W'(g)) rd_mux = rd_b[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    assign irq = |irq_b;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int NP = 116
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic [31:0]   rd_data,
    input logic [NP-1:0] pin_out,
    input logic [NP-1:0] pin_oe,
    input logic          irq
);
    assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_out == '0 && pin_oe == '0 && !irq));

    assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pin_out));

    assert_oe_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pin_oe));

    assert_irq_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(wr_en));

    assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NP(NPINS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq)
);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
    localparam int NPINS = 3 * 32 + 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [8:0]       addr = '0;
    logic [31:0]      wr_data = '0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [31:0]      rd_data;
    logic [NPINS-1:0] pin_in = '0;
    logic [NPINS-1:0] pin_out, pin_oe;
    logic             irq;
    int               checks = 0;
    int               errors = 0;
    logic [31:0]      rv;

    always #2 clk = ~clk;

    gpio_bank_ctrl u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [8:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 9'h014, 32'h0, 32'h03C0_0000},  // R10 R5 inverted pins read 1
        '{1'b0, 9'h10C, 32'h0, 32'h0},          // R10 bank 3 direction
        '{1'b0, 9'h048, 32'h0, 32'h0},          // R10 status
        '{1'b0, 9'h09C, 32'h0, 32'h0},          // R10 mask
        '{1'b1, 9'h010, 32'h0000_A5A5, 32'h0},
        '{1'b0, 9'h010, 32'h0, 32'h0000_A5A5},  // R2 bank 1 direction
        '{1'b0, 9'h00C, 32'h0, 32'h0},          // R2 bank 0 untouched
        '{1'b1, 9'h10C, 32'hFFFF_FFFF, 32'h0},
        '{1'b0, 9'h10C, 32'h0, 32'h000F_FFFF},  // R8 top bits of last bank
        '{1'b1, 9'h130, 32'h0000_0F0F, 32'h0},
        '{1'b0, 9'h130, 32'h0, 32'h0000_0F0F},  // R2 high window
        '{1'b0, 9'h104, 32'h0, 32'h0},          // R1 hole
        '{1'b1, 9'h018, 32'h0000_00FF, 32'h0},
        '{1'b0, 9'h018, 32'h0, 32'h0},          // R3 set reads zero
        '{1'b0, 9'h1A4, 32'h0, 32'h0}           // R1 absent bank
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [8:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].a, VECS[i].d);
            else begin
                rd(VECS[i].a, rv);
                check($sformatf("table %0d (R1,R2,R3,R5,R8,R10)", i), rv, VECS[i].exp);
            end
        end

        do_reset();
        // R10 reset outputs
        check("R10 pin_out low", pin_out[31:0] | pin_out[63:32] | pin_out[95:64] | 32'(pin_out[115:96]), 32'h0);
        check("R10 pin_oe low", pin_oe[31:0] | pin_oe[63:32] | pin_oe[95:64] | 32'(pin_oe[115:96]), 32'h0);
        check("R10 irq low", 32'(irq), 32'h0);

        // R3 set / clear strobes
        wr(9'h00C, 32'hFFFF_FFFF);
        check("R5 bank0 all outputs", pin_oe[31:0], 32'hFFFF_FFFF);
        wr(9'h018, 32'h0000_00F0);
        check("R3 set", pin_out[31:0], 32'h0000_00F0);
        wr(9'h018, 32'h0000_0003);
        check("R3 set keeps others", pin_out[31:0], 32'h0000_00F3);
        wr(9'h024, 32'h0000_0030);
        check("R3 clear", pin_out[31:0], 32'h0000_00C3);
        wr(9'h01C, 32'h0000_0001);
        check("R2 bank1 set", pin_out[63:32], 32'h0000_0001);
        check("R2 bank0 unchanged", pin_out[31:0], 32'h0000_00C3);

        // R5 inverted polarity
        wr(9'h014, 32'h0);
        check("R5 inverted pins drive on 0", pin_oe[95:64], 32'h03C0_0000);
        wr(9'h014, 32'h03C0_0000);
        check("R5 inverted pins off on 1", pin_oe[95:64], 32'h0);

        // R8 unimplemented bits of the last bank
        wr(9'h118, 32'hFFFF_FFFF);
        check("R8 last bank outputs", 32'(pin_out[115:96]), 32'h000F_FFFF);
        pin_in[115:96] = '1;
        settle();
        rd(9'h100, rv);
        check("R8 last bank level", rv, 32'h000F_FFFF);

        // R4 level readback latency and direction independence
        pin_in[31:0] = 32'h1234_5678;
        settle();
        rd(9'h000, rv);
        check("R4 level on output pins", rv, 32'h1234_5678);
        @(negedge clk);
        pin_in[63:32] = 32'hDEAD_BEEF;
        rd(9'h004, rv);
        check("R4 level not yet through sync", rv, 32'h0);
        rd(9'h004, rv);
        check("R4 level after two flops", rv, 32'hDEAD_BEEF);

        // R6 edge status
        pin_in[63:32] = '0;
        settle();
        wr(9'h034, 32'h1);
        wr(9'h0A0, 32'hFFFF_FFFF);
        pin_in[32] = 1'b1;
        settle();
        rd(9'h04C, rv);
        check("R6 rising edge sets status", rv, 32'h1);
        check("R7 irq on unmasked status", 32'(irq), 32'h1);
        wr(9'h04C, 32'h0);
        rd(9'h04C, rv);
        check("R6 zero write keeps status", rv, 32'h1);
        wr(9'h04C, 32'h1);
        rd(9'h04C, rv);
        check("R6 w1c clears", rv, 32'h0);
        check("R7 irq drops after clear", 32'(irq), 32'h0);
        pin_in[32] = 1'b0;
        settle();
        rd(9'h04C, rv);
        check("R6 disabled fall ignored", rv, 32'h0);
        wr(9'h040, 32'h2);
        pin_in[33] = 1'b1;
        settle();
        rd(9'h04C, rv);
        check("R6 rise without enable ignored", rv, 32'h0);
        pin_in[33] = 1'b0;
        settle();
        rd(9'h04C, rv);
        check("R6 falling edge sets status", rv, 32'h2);

        // R7 masking
        wr(9'h0A0, 32'h0);
        check("R7 masked status no irq", 32'(irq), 32'h0);
        rd(9'h04C, rv);
        check("R7 masked status still readable", rv, 32'h2);
        wr(9'h0A0, 32'h2);
        check("R7 unmask raises irq", 32'(irq), 32'h1);
        wr(9'h04C, 32'h2);

        // R2 bank 3 in the high window
        pin_in[96] = 1'b0;
        settle();
        wr(9'h130, 32'h1);
        wr(9'h19C, 32'h1);
        pin_in[96] = 1'b1;
        settle();
        rd(9'h148, rv);
        check("R2 bank3 status", rv, 32'h1);
        check("R2 bank3 irq", 32'(irq), 32'h1);
        wr(9'h148, 32'h1);

        // R9 edge coincident with clear
        wr(9'h0A0, 32'hFFFF_FFFF);
        pin_in[32] = 1'b1;
        settle();
        pin_in[32] = 1'b0;
        settle();
        @(negedge clk);
        pin_in[32] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr = 9'h04C; wr_data = 32'h1; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(9'h04C, rv);
        check("R9 edge beats clear", rv, 32'h1);
        wr(9'h04C, 32'h1);
        rd(9'h04C, rv);
        check("R9 later clear works", rv, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule